// File: doc/BRIEF.md
# Windowed Watchdog Timer

This peripheral guards a processor against software that stops servicing it. A 12-bit counter counts down by one on each slow tick strobe, which nominally arrives at 256 Hz. The longest timeout is therefore about sixteen seconds. Software restarts the counter by writing a keyed command to the control register. If the counter reaches zero and is ticked again, the block records an underflow.

The block also enforces a minimum spacing between restarts. A restart that arrives while the counter is still above a programmed window value is flagged as an error. Any restart therefore has to come at least (reload − window) ticks after the previous one. Either fault can raise a level interrupt. Either fault can also emit a one-cycle reset request, aimed at the whole system or at the processor alone.

All behaviour is fixed by a mode register, and that register takes a single write after reset. The same register holds a disable bit and two halt bits. Each halt bit freezes the counter while its matching idle or debug input is asserted.

Top module: `wdt_window`

## Requirements
- R1: After reset the mode register (address 1) reads 0x3FFF2FFF, the status register (address 2) reads 0, the counter holds 0xFFF, and the interrupt and both reset request outputs are low.
- R2: The first write to the mode register stores the written value with bits 31:30 forced to zero, and loads the counter from the new reload field (bits 11:0). Every later mode write leaves both the register and the counter unchanged.
- R3: Each cycle with `tick_en` high decrements the counter. A tick that finds the counter at 0 sets status bit 0 (underflow) and reloads the counter from bits 11:0, so underflow follows exactly reload+1 ticks after a load.
- R4: A restart is a control write (address 0) with bits 31:24 equal to 0xA5 and bit 0 set. It reloads the counter from bits 11:0. A control write with any other key, or without bit 0, has no effect.
- R5: A restart that arrives while the counter is greater than the window field (bits 27:16) sets status bit 1 (error). The counter is still reloaded.
- R6: A status read returns the sticky flags and clears them at the same clock edge. A fault that occurs in the cycle of the read stays set.
- R7: `fault_irq` is high whenever mode bit 12 is set and any status flag is set.
- R8: If mode bit 13 is set, a fault produces a one-cycle reset request in the cycle after the fault. The request goes to `rst_req_cpu` when bit 14 is set and to `rst_req_sys` otherwise. The two outputs are never high together.
- R9: The counter holds its value while `idle_in` is high and mode bit 28 is set, or while `debug_in` is high and mode bit 29 is set.
- R10: While mode bit 15 (disable) is set, ticks leave the counter unchanged, restarts are ignored, and no fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 control, 1 mode, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| tick_en | input | 1 | Slow-clock tick strobe, one bus cycle wide |
| idle_in | input | 1 | Processor idle indication |
| debug_in | input | 1 | Debugger halt indication |
| fault_irq | output | 1 | Level fault interrupt |
| rst_req_sys | output | 1 | System reset request pulse |
| rst_req_cpu | output | 1 | Processor-only reset request pulse |

## Verification
Every result lands at the first clock edge after the stimulus cycle: counter changes, status flags and the interrupt level all follow that edge. The reset request pulse is registered at that same edge, so it is high for exactly the cycle that follows. Stimulus is driven on falling edges. Each bus access or tick therefore occupies one rising edge, and the bench samples outputs at the next falling edge, where the pulse and the new flags are both visible. Read data is combinational, so it is sampled just before the edge that clears the flags.

// File: rtl/wdt_window.sv
module wdt_window #(
  parameter int          CW       = 12,
  parameter logic [7:0]  KEY      = 8'hA5,
  parameter logic [31:0] MODE_RST = 32'h3FFF_2FFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        tick_en,
  input  logic        idle_in,
  input  logic        debug_in,
  output logic        fault_irq,
  output logic        rst_req_sys,
  output logic        rst_req_cpu
);
  localparam logic [31:0] MODE_MASK = 32'h3FFF_FFFF;
  localparam int WIN_LSB = 16;
  localparam int B_FIE = 12, B_RSTEN = 13, B_CPU = 14, B_DIS = 15;
  localparam int B_IDLE = 28, B_DBG = 29;

  logic [31:0]   mode_q;
  logic          locked;
  logic [CW-1:0] cnt;
  logic [1:0]    status_q;

  wire [CW-1:0] reload = mode_q[CW-1:0];
  wire [CW-1:0] window = mode_q[WIN_LSB +: CW];
  wire          dis    = mode_q[B_DIS];

  wire wr      = bus_sel & bus_we;
  wire rd_stat = bus_sel & ~bus_we & (bus_addr == 2'd2);
  wire mode_wr = wr & (bus_addr == 2'd1) & ~locked;
  wire restart_ok = wr & (bus_addr == 2'd0) & (bus_wdata[31:24] == KEY)
                    & bus_wdata[0] & ~dis;

  wire halted = (idle_in & mode_q[B_IDLE]) | (debug_in & mode_q[B_DBG]);
  wire run    = tick_en & ~dis & ~halted;

  wire ev_err = restart_ok & (cnt > window);
  wire ev_unf = run & ~restart_ok & ~mode_wr & (cnt == '0);
  wire fault  = ev_err | ev_unf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      locked <= 1'b0;
    end else if (mode_wr) begin
      mode_q <= bus_wdata & MODE_MASK;
      locked <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '1;
    else if (mode_wr)    cnt <= bus_wdata[CW-1:0];
    else if (restart_ok) cnt <= reload;
    else if (run)        cnt <= (cnt == '0) ? reload : cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (rd_stat ? 2'b00 : status_q) | {ev_err, ev_unf};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_req_sys <= 1'b0;
      rst_req_cpu <= 1'b0;
    end else begin
      rst_req_sys <= fault & mode_q[B_RSTEN] & ~mode_q[B_CPU];
      rst_req_cpu <= fault & mode_q[B_RSTEN] &  mode_q[B_CPU];
    end
  end

  assign fault_irq = mode_q[B_FIE] & (|status_q);

  always_comb begin
    case (bus_addr)
      2'd1:    bus_rdata = mode_q;
      2'd2:    bus_rdata = {30'b0, status_q};
      default: bus_rdata = '0;
    endcase
  end
endmodule

module wdt_window_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [31:0]   mode_q,
  input logic          locked,
  input logic [CW-1:0] cnt,
  input logic          halted,
  input logic          restart_ok,
  input logic          mode_wr,
  input logic [1:0]    status_q,
  input logic          fault_irq,
  input logic          rst_req_sys,
  input logic          rst_req_cpu
);
  a_r2_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(mode_q));

  a_r8_single_pulse_sys: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_sys |=> !rst_req_sys);

  a_r8_single_pulse_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_cpu |=> !rst_req_cpu);

  a_r8_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req_sys && rst_req_cpu));

  a_r9_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !restart_ok && !mode_wr) |=> $stable(cnt));

  a_r7_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
    fault_irq |-> (status_q != 2'b00));

  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[15] |=> (!rst_req_sys && !rst_req_cpu && $stable(cnt)));
endmodule

bind wdt_window wdt_window_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .locked(locked), .cnt(cnt),
  .halted(halted), .restart_ok(restart_ok), .mode_wr(mode_wr),
  .status_q(status_q), .fault_irq(fault_irq),
  .rst_req_sys(rst_req_sys), .rst_req_cpu(rst_req_cpu)
);

// File: tb/wdt_window_tb.sv
`timescale 1ns/1ps
module wdt_window_tb;
  logic clk = 0, rst_n = 0, bus_sel = 0, bus_we = 0;
  logic [1:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  wire  [31:0] bus_rdata;
  logic tick_en = 0, idle_in = 0, debug_in = 0;
  wire  fault_irq, rst_req_sys, rst_req_cpu;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  localparam logic [31:0] RESTART = 32'hA500_0001;

  always #4 clk = ~clk;

  wdt_window u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .idle_in(idle_in), .debug_in(debug_in),
    .fault_irq(fault_irq), .rst_req_sys(rst_req_sys), .rst_req_cpu(rst_req_cpu)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1;
      @(negedge clk); tick_en = 0;
    end
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary;
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] m1;
    logic exp_err, proc;

    do_reset;
    bus_rd(2'd1, d); chk("R1 mode reset value", d, 32'h3FFF_2FFF);
    bus_rd(2'd2, d); chk("R1 status reset", d, 0);
    chk("R1 irq low", fault_irq, 0);
    chk("R1 sys low", rst_req_sys, 0);
    chk("R1 cpu low", rst_req_cpu, 0);

    // R1/R3: default counter 0xFFF underflows on the 4096th tick
    ticks(4095);
    bus_rd(2'd2, d); chk("R1 no underflow at 4095 ticks", d, 0);
    ticks(1);
    chk("R8 default sys pulse", rst_req_sys, 1);
    chk("R8 default cpu quiet", rst_req_cpu, 0);
    chk("R7 irq off without enable", fault_irq, 0);
    @(negedge clk);
    chk("R8 pulse one cycle", rst_req_sys, 0);
    bus_rd(2'd2, d); chk("R6 underflow flag", d, 1);
    bus_rd(2'd2, d); chk("R6 cleared on read", d, 0);

    // R2: write-once, reload 5, window 2, irq enable, idle halt
    do_reset;
    m1 = 32'h1000_0000 | (2 << 16) | 32'h1000 | 5;
    bus_wr(2'd1, m1);
    bus_wr(2'd1, 32'h0000_8003);
    bus_rd(2'd1, d); chk("R2 second mode write ignored", d, m1);
    bus_wr(2'd1, 32'hFFFF_FFFF);
    bus_rd(2'd1, d); chk("R2 later write ignored", d, m1);

    // R4: counter 5 -> 4, invalid commands must neither flag nor reload
    ticks(1);
    bus_wr(2'd0, 32'h5A00_0001);
    bus_wr(2'd0, 32'hA500_0000);
    bus_rd(2'd2, d); chk("R4 bad command no error", d, 0);
    ticks(4);
    bus_rd(2'd2, d); chk("R4 counter not reloaded yet", d, 0);
    ticks(1);
    chk("R7 irq raised", fault_irq, 1);
    bus_rd(2'd2, d); chk("R4 underflow at original time", d, 1);
    chk("R7 irq cleared with flags", fault_irq, 0);

    // R9: idle halt bit set, debug halt bit clear; counter is 5
    idle_in = 1;
    ticks(10);
    bus_rd(2'd2, d); chk("R9 idle halt holds", d, 0);
    idle_in = 0; debug_in = 1;
    ticks(5);
    bus_rd(2'd2, d); chk("R9 debug not halting", d, 0);
    ticks(1);
    bus_rd(2'd2, d); chk("R9 counting resumed", d, 1);
    debug_in = 0;

    // R10: disabled
    do_reset;
    bus_wr(2'd1, 32'h0000_A002);
    ticks(10);
    chk("R10 no reset pulse", rst_req_sys, 0);
    bus_rd(2'd2, d); chk("R10 no underflow", d, 0);
    bus_wr(2'd0, RESTART);
    bus_rd(2'd2, d); chk("R10 restart ignored", d, 0);

    // R8: processor-only reset target
    do_reset;
    bus_wr(2'd1, (1 << 16) | 32'h6000 | 1);
    ticks(2);
    chk("R8 cpu pulse", rst_req_cpu, 1);
    chk("R8 sys quiet", rst_req_sys, 0);

    // R5/R3 sweep over reload, window and restart point
    for (int r = 2; r <= 6; r++)
      for (int w = 0; w <= r; w++)
        for (int k = 0; k <= r; k++) begin
          proc = w[0];
          do_reset;
          bus_wr(2'd1, r | (w << 16) | 32'h3000 | (proc ? 32'h4000 : 32'h0));
          ticks(k);
          bus_wr(2'd0, RESTART);
          exp_err = (r - k) > w;
          chk("R5 irq on early restart", fault_irq, exp_err);
          chk("R8 sys pulse on error", rst_req_sys, exp_err & ~proc);
          chk("R8 cpu pulse on error", rst_req_cpu, exp_err & proc);
          bus_rd(2'd2, d); chk("R5 window error flag", d, {exp_err, 1'b0});
          ticks(r);
          bus_rd(2'd2, d); chk("R3 reload then no early underflow", d, 0);
          ticks(1);
          bus_rd(2'd2, d); chk("R3 underflow after reload+1", d, 1);
        end

    done = 1;
    summary;
    $finish;
  end
endmodule